// File: doc/BRIEF.md
# External Bus Write Lane Steering

This block sits between an internal write requester and an external data bus that is 32 bits wide. It places the bytes of a write onto the correct byte lanes. The lanes are chosen from the transfer size code and the two low address bits. Lanes use big-endian numbering: lane 0 is `bus_data[31:24]`, lane 3 is `bus_data[7:0]`, and the byte at offset 0 of the write data is `req_data[31:24]`.

When the attached device has a 16-bit port, only lanes 0 and 1 carry data. This mode is chosen per request with `req_half_port`, or for the whole bus with the static `bus16_mode` input. In this mode a full-word write is split into two half-word beats.

A request is taken only while the block is idle. Its fields are held in registers until the last beat is acknowledged by `bus_ack`. A misaligned request is refused with a one-cycle error flag, and no beat is issued for it.

Top module: `wr_lane_steer`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `bus_beat`=0 and `bus_lane_vld`=0.
- R2: Size code 01 is a byte. On a 32-bit port, a byte at low address a (0..3) is driven on lane a and only lane a is valid (`bus_lane_vld` bit k marks lane k).
- R3: Size code 10 is a half-word and size code 00 is a word. On a 32-bit port, a half-word at offset 0 uses lanes 0,1 (valid 4'b0011), and one at offset 2 uses lanes 2,3 (valid 4'b1100). A word at offset 0 uses all four lanes, with offset 0 on lane 0.
- R4: On a 16-bit port, a byte with address bit 0 equal to 0 goes on lane 0, and one with that bit equal to 1 goes on lane 1, whatever address bit 1 is.
- R5: On a 16-bit port, a half-word at offset 0 or 2 goes on lanes 0,1. `bus_lo` and `bus_size` repeat the request's values.
- R6: On a 16-bit port, a word becomes two beats, each with size code 10 and lanes 0,1 valid. The first beat carries offsets 0,1 with `bus_lo`=00. The second carries offsets 2,3 with `bus_lo`=10.
- R7: A beat's outputs stay stable until `bus_ack` is seen. `req_done` pulses only in the cycle of `bus_ack` for the request's last beat.
- R8: A request is refused in its accepting cycle with `req_err`=1, and no beat follows, in any of these cases: a half-word at an odd address, a word at a nonzero offset, or size code 11.
- R9: `bus16_mode`=1 gives the 16-bit port behaviour even when `req_half_port`=0.
- R10: While a beat is pending, `req_ready`=0. New request inputs, including an asserted `req_valid`, have no effect on the beats in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus16_mode | input | 1 | Forces 16-bit port behaviour |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_lo | input | 2 | Low address bits (bit 1 = A30, bit 0 = A31) |
| req_size | input | 2 | Size code: 01 byte, 10 half, 00 word |
| req_data | input | 32 | Write data, offset 0 in [31:24] |
| req_half_port | input | 1 | Target has a 16-bit port |
| req_err | output | 1 | Misaligned request refused |
| req_done | output | 1 | Last beat acknowledged |
| bus_data | output | 32 | Lane data |
| bus_lane_vld | output | 4 | Per-lane valid, bit k = lane k |
| bus_size | output | 2 | Size code of this beat |
| bus_lo | output | 2 | Low address bits of this beat |
| bus_beat | output | 1 | Beat pending |
| bus_ack | input | 1 | Bus takes the beat |

## Verification
The tests cover both port widths and all three sizes. Byte writes are tried at every offset, and half-words at both offsets. A 32-bit port offset 3 byte lands on lane 3, while a 16-bit port one lands on lane 1, which shows whether only address bit 0 is used. The split word on a 16-bit port shows the two beats are ordered and have the right address. This is repeated with `bus16_mode` set and the port select clear. The bus acknowledge stalls every third cycle, to show that beat outputs hold. An asserted request during a beat shows that the held fields are not disturbed. Every misaligned form is sent on both port widths to confirm no beat follows.

// File: rtl/wr_lane_steer.sv
module wr_lane_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16_mode,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_lo,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_data,
  input  logic        req_half_port,
  output logic        req_err,
  output logic        req_done,
  output logic [31:0] bus_data,
  output logic [3:0]  bus_lane_vld,
  output logic [1:0]  bus_size,
  output logic [1:0]  bus_lo,
  output logic        bus_beat,
  input  logic        bus_ack
);
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_B1, S_B2} st_t;
  st_t st;

  logic [1:0]  h_lo, h_size;
  logic [31:0] h_data;
  logic        h_p16;

  logic bad, take, split, last, hi16;
  logic [15:0] pair;
  logic [3:0]  vld_w;

  assign bad = (req_size == 2'b11)
             | (req_size == SZ_HALF && req_lo[0])
             | (req_size == SZ_WORD && req_lo != 2'b00);

  assign req_ready = (st == S_IDLE);
  assign take      = req_valid & req_ready;
  assign req_err   = take & bad;
  assign bus_beat  = (st != S_IDLE);
  assign split     = h_p16 & (h_size == SZ_WORD);
  assign last      = !split | (st == S_B2);
  assign req_done  = bus_beat & bus_ack & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      h_lo   <= 2'b00;
      h_size <= SZ_BYTE;
      h_data <= 32'h0;
      h_p16  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take && !bad) begin
          h_lo   <= req_lo;
          h_size <= req_size;
          h_data <= req_data;
          h_p16  <= req_half_port | bus16_mode;
          st     <= S_B1;
        end
        S_B1: if (bus_ack) st <= split ? S_B2 : S_IDLE;
        S_B2: if (bus_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hi16 = (st == S_B2) | ((h_size != SZ_WORD) & h_lo[1]);
  assign pair = hi16 ? h_data[15:0] : h_data[31:16];
  assign bus_data = h_p16 ? {pair, h_data[15:0]} : h_data;

  always_comb begin
    if (h_p16) begin
      if (h_size == SZ_BYTE) vld_w = h_lo[0] ? 4'b0010 : 4'b0001;
      else                   vld_w = 4'b0011;
    end else begin
      case (h_size)
        SZ_BYTE: vld_w = 4'b0001 << h_lo;
        SZ_HALF: vld_w = h_lo[1] ? 4'b1100 : 4'b0011;
        default: vld_w = 4'b1111;
      endcase
    end
  end

  assign bus_lane_vld = bus_beat ? vld_w : 4'b0000;
  assign bus_lo   = split ? ((st == S_B2) ? 2'b10 : 2'b00) : h_lo;
  assign bus_size = split ? SZ_HALF : h_size;
endmodule

module wr_lane_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_err,
  input logic        req_done,
  input logic [31:0] bus_data,
  input logic [3:0]  bus_lane_vld,
  input logic [1:0]  bus_size,
  input logic [1:0]  bus_lo,
  input logic        bus_beat,
  input logic        bus_ack
);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_beat && !bus_ack |=> bus_beat && $stable(bus_data) && $stable(bus_lane_vld)
                             && $stable(bus_lo) && $stable(bus_size));
  a_r7_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> bus_beat && bus_ack);
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_beat |-> !req_ready);
  a_r8_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !bus_beat);
  a_r6_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_beat && bus_ack && !req_done |=> bus_beat && bus_lo == 2'b10
                                         && bus_size == 2'b10 && bus_lane_vld == 4'b0011);
  a_r1_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_beat |-> bus_lane_vld == 4'b0000);
endmodule

bind wr_lane_steer wr_lane_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .req_done(req_done), .bus_data(bus_data), .bus_lane_vld(bus_lane_vld),
  .bus_size(bus_size), .bus_lo(bus_lo), .bus_beat(bus_beat), .bus_ack(bus_ack));

// File: tb/sim_wr_lane_steer.sv
module sim_wr_lane_steer;
  logic clk = 0, rst_n = 0;
  logic bus16_mode = 0, req_valid = 0, req_half_port = 0, bus_ack = 0;
  logic [1:0] req_lo = 0, req_size = 0;
  logic [31:0] req_data = 0;
  logic req_ready, req_err, req_done, bus_beat;
  logic [31:0] bus_data;
  logic [3:0] bus_lane_vld;
  logic [1:0] bus_size, bus_lo;

  wr_lane_steer u0 (.*);

  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] d; logic [3:0] v; logic [1:0] lo; logic [1:0] sz; logic last;
  } beat_t;
  beat_t q[$];
  string tq[$];
  int vectors = 0, errs = 0;

  function automatic logic [7:0] op(input logic [31:0] w, input int k);
    return w[31-8*k -: 8];
  endfunction

  function automatic logic [31:0] place(input logic [7:0] b, input int lane);
    return {24'h0, b} << (8*(3-lane));
  endfunction

  function automatic void push(input beat_t b, input string t);
    q.push_back(b); tq.push_back(t);
  endfunction

  // expected beats from the requirement text
  function automatic void expect_req(input logic [1:0] a, input logic [1:0] sz,
                                     input logic [31:0] w, input logic p16, input string t);
    beat_t b;
    b.lo = a; b.sz = sz; b.last = 1; b.d = 0;
    if (!p16) begin
      case (sz)
        2'b01: begin b.v = 4'b0001 << a; b.d = place(op(w, a), a); end
        2'b10: begin b.v = a[1] ? 4'b1100 : 4'b0011; b.d = w; end
        default: begin b.v = 4'b1111; b.d = w; end
      endcase
      push(b, t);
    end else if (sz == 2'b01) begin
      b.v = a[0] ? 4'b0010 : 4'b0001;
      b.d = place(op(w, a), a[0]);
      push(b, t);
    end else if (sz == 2'b10) begin
      b.v = 4'b0011;
      b.d = place(op(w, a), 0) | place(op(w, a + 1), 1);
      push(b, t);
    end else begin
      b.v = 4'b0011; b.sz = 2'b10; b.lo = 2'b00; b.last = 0;
      b.d = place(op(w, 0), 0) | place(op(w, 1), 1);
      push(b, t);
      b.lo = 2'b10; b.last = 1;
      b.d = place(op(w, 2), 0) | place(op(w, 3), 1);
      push(b, t);
    end
  endfunction

  function automatic void chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endfunction

  // acknowledge stalls every third cycle
  int cyc = 0;
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    bus_ack = (cyc % 3 != 1);
  end

  // monitor
  beat_t prev; bit stalled = 0;
  always @(negedge clk) if (rst_n) begin
    if (bus_beat) begin
      if (stalled)
        chk({bus_data, bus_lane_vld, bus_lo, bus_size} == {prev.d, prev.v, prev.lo, prev.sz},
            "R7 hold", {bus_data, bus_lane_vld, bus_lo, bus_size}, {prev.d, prev.v, prev.lo, prev.sz});
      if (req_ready) chk(0, "R10 ready during beat", req_ready, 0);
      if (bus_ack) begin
        if (q.size() == 0) chk(0, "R8 unexpected beat", bus_lane_vld, 0);
        else begin
          beat_t e; string t;
          logic [31:0] m;
          e = q.pop_front(); t = tq.pop_front();
          m = {{8{e.v[0]}}, {8{e.v[1]}}, {8{e.v[2]}}, {8{e.v[3]}}};
          chk((bus_data & m) == (e.d & m) && bus_lane_vld == e.v && bus_lo == e.lo && bus_size == e.sz,
              t, {bus_data & m, bus_lane_vld, bus_lo, bus_size}, {e.d & m, e.v, e.lo, e.sz});
          chk(req_done == e.last, "R7 done on last ack", req_done, e.last);
        end
        stalled = 0;
      end else begin
        stalled = 1;
        prev = '{d: bus_data, v: bus_lane_vld, lo: bus_lo, sz: bus_size, last: 0};
      end
    end else begin
      stalled = 0;
      if (req_done) chk(0, "R7 done while idle", req_done, 0);
    end
  end

  task automatic send(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] w,
                      input logic p16, input bit bad, input string t);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_lo = a; req_size = sz; req_data = w; req_half_port = p16;
    #0.5;
    chk(req_err == bad, "R8 err flag", req_err, bad);
    if (!bad) expect_req(a, sz, w, p16 | bus16_mode, t);
    @(posedge clk); #1;
    // R10: a different request asserted while busy must not disturb the held fields
    req_valid = !bad; req_lo = ~a; req_size = 2'b01; req_data = ~w; req_half_port = ~p16;
    @(posedge clk); #1;
    req_valid = 0;
    if (bad) begin
      @(negedge clk);
      chk(!bus_beat, "R8 no beat after refusal", bus_beat, 0);
    end
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1 && bus_beat === 0 && bus_lane_vld === 0, "R1 reset",
        {req_ready, bus_beat, bus_lane_vld}, {1'b1, 1'b0, 4'b0});
    rst_n = 1;
    // R2 bytes on a 32-bit port
    for (int a = 0; a < 4; a++) send(a[1:0], 2'b01, 32'hA1B2C3D4, 0, 0, "R2 byte lane");
    // R3 halves and word on a 32-bit port
    send(2'b00, 2'b10, 32'h11223344, 0, 0, "R3 half 0");
    send(2'b10, 2'b10, 32'h55667788, 0, 0, "R3 half 2");
    send(2'b00, 2'b00, 32'h99AABBCC, 0, 0, "R3 word");
    // R4 bytes on a 16-bit port
    for (int a = 0; a < 4; a++) send(a[1:0], 2'b01, 32'h0F1E2D3C, 1, 0, "R4 byte 16");
    // R5 halves on a 16-bit port
    send(2'b00, 2'b10, 32'hDEADBEEF, 1, 0, "R5 half 0");
    send(2'b10, 2'b10, 32'hCAFEF00D, 1, 0, "R5 half 2");
    // R6 split word
    send(2'b00, 2'b00, 32'h01234567, 1, 0, "R6 split word");
    send(2'b00, 2'b00, 32'h89ABCDEF, 1, 0, "R6 split word");
    // R9 bus-wide 16-bit mode
    bus16_mode = 1;
    send(2'b11, 2'b01, 32'h13579BDF, 0, 0, "R9 byte mode");
    send(2'b10, 2'b01, 32'h2468ACE0, 0, 0, "R9 byte mode");
    send(2'b00, 2'b00, 32'hFEDCBA98, 0, 0, "R9 split word");
    bus16_mode = 0;
    // R8 misaligned requests on both widths
    for (int p = 0; p < 2; p++) begin
      send(2'b01, 2'b10, 32'h1, p[0], 1, "R8");
      send(2'b11, 2'b10, 32'h2, p[0], 1, "R8");
      send(2'b01, 2'b00, 32'h3, p[0], 1, "R8");
      send(2'b10, 2'b00, 32'h4, p[0], 1, "R8");
      send(2'b00, 2'b11, 32'h5, p[0], 1, "R8");
    end
    send(2'b01, 2'b01, 32'h77665544, 0, 0, "R2 byte after refusals");
    for (int i = 0; i < 200 && (q.size() != 0 || bus_beat); i++) @(negedge clk);
    chk(q.size() == 0, "R7 all beats acknowledged", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule